// File: doc/BRIEF.md
# Chip-level interrupt cause and enable aggregator

This block gathers the interrupt sources of a storage host into one chip-level cause word and drives a single interrupt line. The sources are a done event and an error event for each port in two groups of four ports, a coalescing-done flag for each group, a coalescing-done flag covering all ports, a PCI error event, and low and high transaction-coalescing done flags. The cause word is sampled once per clock and is never sticky. To clear a cause bit, software clears it at the block that drives it.

Software writes an enable word and reads either the enable word or the cause word through a plain register port. The register port is control traffic, not a data stream, so it has no valid/ready handshake. A write is taken on any clock with the write strobe high, and read data is combinational on the selector. When a coalescing-done enable for a port group is written as 1, hardware forces the per-port done enables of that group to 0 before they are stored. The coalesced interrupt and the individual done interrupts of a group therefore can never both be enabled. The interrupt output is the OR of cause AND enable, taken from the registered words.

Top module: `irq_cause_aggregator`

## Requirements
- R1: After reset the enable word and the cause word read as 0, and `irq` is 0.
- R2: Cause bit layout, for port p (0..3) of group g (0..1): the error event is at bit 9g+2p and the done event is at bit 9g+2p+1. The group coalescing-done flag is at bit 9g+8. The PCI error is at bit 18, transaction-coalescing low at bit 19, high at bit 20, and all-ports coalescing-done at bit 21. Bits 22..31 read 0. The cause word shows the sources as they were at the previous rising clock edge. Reading with `reg_sel`=0 returns the cause word.
- R3: A write with `reg_wr`=1 and `reg_sel`=1 updates the enable word at that edge. Reading with `reg_sel`=1 returns the stored enable word, with bits 22..31 always 0.
- R4: If bit 8 or bit 21 of the written data is 1, bits 1, 3, 5 and 7 of the stored enable word are 0.
- R5: If bit 17 or bit 21 of the written data is 1, bits 10, 12, 14 and 16 of the stored enable word are 0.
- R6: `irq` is 1 exactly when some bit is 1 in both the cause word and the enable word. It changes in the same cycle as the read-back of those words.
- R7: A write with `reg_sel`=0 leaves the enable word unchanged, because the cause word is read-only.
- R8: A cause bit falls to 0 one cycle after its source falls, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_done | input | 8 | Per-port done events; index 4g+p |
| port_err | input | 8 | Per-port error events; index 4g+p |
| grp_coal_done | input | 2 | Coalescing-done flag per port group |
| all_coal_done | input | 1 | Coalescing-done flag for all ports |
| pci_err | input | 1 | PCI error event |
| xact_coal_lo | input | 1 | Transaction-coalescing low done |
| xact_coal_hi | input | 1 | Transaction-coalescing high done |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 1 | 0 selects the cause word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| irq | output | 1 | Chip interrupt |

## Verification
A bad stored enable bit shows up on `reg_rdata` on the first cycle after the write that stored it. It also shows on `irq` as soon as the matching source fires. The bench compares both outputs on every cycle against a behavioural model, so such a fault is caught within one clock. A misplaced source bit, or a cause bit that latches, shows in the cause read-back one cycle after the source moves. Writes that carry the group and all-ports coalescing enables together with every done enable make any break in the exclusion rule visible on the read-back.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {SEL_CAUSE = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;

  function automatic int grp_stride(int ports);
    return 2 * ports + 1;
  endfunction

  function automatic int err_bit(int g, int p, int ports);
    return g * grp_stride(ports) + 2 * p;
  endfunction

  function automatic int done_bit(int g, int p, int ports);
    return g * grp_stride(ports) + 2 * p + 1;
  endfunction

  function automatic int coal_bit(int g, int ports);
    return g * grp_stride(ports) + 2 * ports;
  endfunction

  function automatic int pci_bit(int groups, int ports);
    return groups * grp_stride(ports);
  endfunction

  function automatic int word_width(int groups, int ports);
    return groups * grp_stride(ports) + 4;
  endfunction
endpackage

// File: rtl/irq_cause_collect.sv
module irq_cause_collect
  import irq_agg_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int PORTS  = 4,
  localparam int NP = GROUPS * PORTS,
  localparam int W  = word_width(GROUPS, PORTS),
  localparam int PB = pci_bit(GROUPS, PORTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   port_done,
  input  logic [NP-1:0]   port_err,
  input  logic [GROUPS-1:0] grp_coal_done,
  input  logic            all_coal_done,
  input  logic            pci_err,
  input  logic            xact_coal_lo,
  input  logic            xact_coal_hi,
  output logic [W-1:0]    cause_q
);
  logic [W-1:0] src_word;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign src_word[err_bit(g, p, PORTS)]  = port_err[g*PORTS+p];
      assign src_word[done_bit(g, p, PORTS)] = port_done[g*PORTS+p];
    end
    assign src_word[coal_bit(g, PORTS)] = grp_coal_done[g];
  end
  assign src_word[PB]   = pci_err;
  assign src_word[PB+1] = xact_coal_lo;
  assign src_word[PB+2] = xact_coal_hi;
  assign src_word[PB+3] = all_coal_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= src_word;
  end

  // R8: a source that fell is gone from the cause word one cycle later
  a_r8_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_err) |=> !cause_q[PB]);

  // R2: the all-ports flag appears at the top position one cycle later
  a_r2_all_coal_pos: assert property (@(posedge clk) disable iff (!rst_n)
    all_coal_done |=> cause_q[PB+3]);
endmodule

// File: rtl/irq_enable_store.sv
module irq_enable_store
  import irq_agg_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int PORTS  = 4,
  localparam int W  = word_width(GROUPS, PORTS),
  localparam int AB = pci_bit(GROUPS, PORTS) + 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  logic [W-1:0] masked;

  always_comb begin
    masked = wdata;
    for (int g = 0; g < GROUPS; g++) begin
      if (wdata[coal_bit(g, PORTS)] || wdata[AB]) begin
        for (int p = 0; p < PORTS; p++) masked[done_bit(g, p, PORTS)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= masked;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    logic [PORTS-1:0] grp_done_en;
    for (genvar p = 0; p < PORTS; p++) begin : g_bit
      assign grp_done_en[p] = en_q[done_bit(g, p, PORTS)];
    end
    // R4 (group 0) and R5 (group 1): coalesced and per-port done enables never coexist
    a_r4_r5_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[coal_bit(g, PORTS)] || en_q[AB]) |-> (grp_done_en == '0));
  end

  // R7: without a write strobe the stored word holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause,
  input  logic [W-1:0] enable,
  output logic         irq
);
  assign irq = |(cause & enable);

  // R6: nothing enabled means no interrupt
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  // R6: an interrupt always has an enabled cause behind it
  a_r6_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cause != '0));
endmodule

// File: rtl/irq_cause_aggregator.sv
module irq_cause_aggregator
  import irq_agg_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int PORTS  = 4,
  parameter int DW     = 32,
  localparam int NP = GROUPS * PORTS,
  localparam int W  = word_width(GROUPS, PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     port_done,
  input  logic [NP-1:0]     port_err,
  input  logic [GROUPS-1:0] grp_coal_done,
  input  logic              all_coal_done,
  input  logic              pci_err,
  input  logic              xact_coal_lo,
  input  logic              xact_coal_hi,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic [W-1:0] cause_q;
  logic [W-1:0] en_q;
  logic         en_wr;

  assign en_wr = reg_wr && (reg_sel == SEL_ENABLE);

  irq_cause_collect #(.GROUPS(GROUPS), .PORTS(PORTS)) u_collect (
    .clk(clk), .rst_n(rst_n), .port_done(port_done), .port_err(port_err),
    .grp_coal_done(grp_coal_done), .all_coal_done(all_coal_done),
    .pci_err(pci_err), .xact_coal_lo(xact_coal_lo), .xact_coal_hi(xact_coal_hi),
    .cause_q(cause_q)
  );

  irq_enable_store #(.GROUPS(GROUPS), .PORTS(PORTS)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_en(en_wr), .wdata(reg_wdata[W-1:0]),
    .en_q(en_q)
  );

  irq_out_gate #(.W(W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cause(cause_q), .enable(en_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[W-1:0] = (reg_sel == SEL_ENABLE) ? en_q : cause_q;
  end

  if (DW > W) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DW-1:W];
    // R3: bits above the layout never read as 1
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DW-1:W] == '0);
  end
endmodule

// File: tb/test_irq_cause_aggregator.sv
module test_irq_cause_aggregator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  port_done = '0, port_err = '0;
  logic [1:0]  grp_coal_done = '0;
  logic        all_coal_done = 1'b0, pci_err = 1'b0;
  logic        xact_coal_lo = 1'b0, xact_coal_hi = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_aggregator i_irq_cause_aggregator (
    .clk(clk), .rst_n(rst_n), .port_done(port_done), .port_err(port_err),
    .grp_coal_done(grp_coal_done), .all_coal_done(all_coal_done),
    .pci_err(pci_err), .xact_coal_lo(xact_coal_lo), .xact_coal_hi(xact_coal_hi),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural model from the requirements
  logic [31:0] m_cause = '0, m_en = '0;

  function automatic logic [31:0] src_word();
    logic [31:0] w = '0;
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 4; p++) begin
        w[9*g + 2*p]     = port_err[4*g + p];
        w[9*g + 2*p + 1] = port_done[4*g + p];
      end
      w[9*g + 8] = grp_coal_done[g];
    end
    w[18] = pci_err; w[19] = xact_coal_lo; w[20] = xact_coal_hi; w[21] = all_coal_done;
    return w;
  endfunction

  function automatic logic [31:0] en_rule(logic [31:0] d);
    logic [31:0] r = d & 32'h003F_FFFF;
    if (d[8]  || d[21]) r = r & ~32'h0000_00AA;
    if (d[17] || d[21]) r = r & ~32'h0001_5400;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause <= '0; m_en <= '0;
    end else begin
      m_cause <= src_word();
      if (reg_wr && reg_sel) m_en <= en_rule(reg_wdata);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(reg_sel ? "R3 enable readback" : "R2 cause readback",
            reg_rdata, reg_sel ? m_en : m_cause);
      check("R6 irq", {31'b0, irq}, {31'b0, |(m_cause & m_en)});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write(logic sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_sel = 1'b1;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; #1;
    check("R1 cause at reset", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1;
    check("R1 enable at reset", reg_rdata, 32'h0);
    check("R1 irq at reset", {31'b0, irq}, 32'h0);
    step();

    write(1'b1, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R4 R5 all-ports clears both groups", reg_rdata, 32'h003E_AB55);
    step();
    write(1'b1, 32'h0001_55AA);
    @(negedge clk);
    check("R4 group0 coal clears low done", reg_rdata, 32'h0001_5500);
    step();
    write(1'b1, 32'h0003_54AA);
    @(negedge clk);
    check("R5 group1 coal clears high done", reg_rdata, 32'h0002_00AA);
    step();
    write(1'b1, 32'h0001_54AA);
    @(negedge clk);
    check("R3 done enables kept without coal", reg_rdata, 32'h0001_54AA);
    step();

    write(1'b0, 32'h0000_0000);
    @(negedge clk);
    check("R7 cause write ignored", reg_rdata, 32'h0001_54AA);
    step();

    port_done[2] = 1'b1; port_err[5] = 1'b1;
    step();
    reg_sel = 1'b0;
    @(negedge clk);
    check("R2 done p2 and err p5 positions", reg_rdata, 32'h0000_0820);
    check("R6 irq from done p2", {31'b0, irq}, 32'h1);
    step();
    port_done[2] = 1'b0; port_err[5] = 1'b0;
    step();
    @(negedge clk);
    check("R8 cause clears after source", reg_rdata, 32'h0);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
    step();

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      port_done = r[7:0]; port_err = r[15:8]; grp_coal_done = r[17:16];
      all_coal_done = r[18]; pci_err = r[19]; xact_coal_lo = r[20]; xact_coal_hi = r[21];
      reg_sel = r[22];
      if (r[25:23] == 3'd0) begin
        reg_wr = 1'b1; reg_wdata = $urandom; reg_sel = r[26];
        if (r[27]) reg_wdata[8] = 1'b0;
        if (r[28]) reg_wdata[21] = 1'b0;
      end else reg_wr = 1'b0;
      step();
    end
    reg_wr = 1'b0;
    repeat (2) step();
    finish_run();
  end
endmodule